// File: doc/BRIEF.md
# Serial Keyboard Command Decoder

This block sits behind a serial byte receiver and turns typed keys into game commands. Four letter keys choose a drawing colour from a fixed palette of four 9-bit RGB values. One more letter key requests a game start. The chosen colour is held in a small register. A multiplexer turns that register into the foreground RGB value.

The RGB output is gated by two flags. One says the current pixel belongs to a drawn object. The other says the beam is inside the visible area. Unless both are high, the output is all zeros, so the monitor never sees colour during blanking.

Bytes arrive from a receiver running at 115200 baud on a 25 MHz clock. That gives thousands of clocks between strobes, so the decoder acts on one strobe at a time and keeps no queue. Key matching ignores letter case.

Top module: `kbd_cmd_decoder`

## Requirements
- R1: After reset, the selected colour is white (9'h1FF) and `start_pulse` is low.
- R2: A strobed byte 0x51 or 0x71 selects white, 9'h1FF. The RGB bits are red in [8:6], green in [5:3] and blue in [2:0].
- R3: A strobed byte 0x57 or 0x77 selects red, 9'h1C0.
- R4: A strobed byte 0x45 or 0x65 selects green, 9'h038.
- R5: A strobed byte 0x52 or 0x72 selects blue, 9'h007.
- R6: A strobed byte 0x54 or 0x74 makes `start_pulse` high for exactly one clock, in the cycle after the strobe. It leaves the colour unchanged.
- R7: A strobed byte that is not one of the ten codes above changes neither the colour nor `start_pulse`.
- R8: A byte presented while `rx_valid` is low has no effect.
- R9: `fg_rgb` equals the selected colour when `draw_px` and `video_active` are both high, and is zero otherwise.
- R10: A new colour shows on `fg_rgb` in the clock cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| draw_px | input | 1 | Current pixel belongs to a drawn object |
| video_active | input | 1 | Current pixel lies in the visible area |
| fg_rgb | output | 9 | Gated foreground colour, 3 bits per channel |
| start_pulse | output | 1 | One-cycle game start request |

## Verification
The hardest thing to show is that the 246 non-command byte values have no effect, along with every byte presented without a strobe. Such a byte could leave the colour register unchanged by luck if it happened to select the colour already held. To rule that out, the bench first moves the colour away from white and then sweeps every byte value. After each byte it reads the colour back through an ungated pixel. The blanking gate is checked for every flag combination while each palette entry is selected, so a mux stuck at one colour cannot pass.

// File: rtl/kbd_cmd_decoder.sv
module kbd_cmd_decoder #(
  parameter logic [8:0] COLOR_Q = 9'h1FF,
  parameter logic [8:0] COLOR_W = 9'h1C0,
  parameter logic [8:0] COLOR_E = 9'h038,
  parameter logic [8:0] COLOR_R = 9'h007
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  input  logic       draw_px,
  input  logic       video_active,
  output logic [8:0] fg_rgb,
  output logic       start_pulse
);
  localparam logic [7:0] CASE_BIT = 8'h20;
  localparam logic [7:0] KEY_Q = 8'h71;
  localparam logic [7:0] KEY_W = 8'h77;
  localparam logic [7:0] KEY_E = 8'h65;
  localparam logic [7:0] KEY_R = 8'h72;
  localparam logic [7:0] KEY_T = 8'h74;

  logic [7:0] key_lc;
  logic [1:0] sel;
  logic [8:0] color;

  assign key_lc = rx_byte | CASE_BIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel         <= 2'd0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= rx_valid && (key_lc == KEY_T);
      if (rx_valid) begin
        case (key_lc)
          KEY_Q:   sel <= 2'd0;
          KEY_W:   sel <= 2'd1;
          KEY_E:   sel <= 2'd2;
          KEY_R:   sel <= 2'd3;
          default: sel <= sel;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      2'd0:    color = COLOR_Q;
      2'd1:    color = COLOR_W;
      2'd2:    color = COLOR_E;
      default: color = COLOR_R;
    endcase
  end

  assign fg_rgb = (draw_px && video_active) ? color : 9'h000;
endmodule

module kbd_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       draw_px,
  input logic       video_active,
  input logic [8:0] fg_rgb,
  input logic       start_pulse
);
  logic [7:0] lc;
  logic       shown;
  logic       is_cmd;
  assign lc     = rx_byte | 8'h20;
  assign shown  = draw_px && video_active;
  assign is_cmd = (lc == 8'h71) || (lc == 8'h77) || (lc == 8'h65) || (lc == 8'h72);

  a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !shown |-> fg_rgb == 9'h000);

  a_r6_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(rx_valid) && ($past(lc) == 8'h74)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rx_valid) && shown && $past(shown)) |-> fg_rgb == $past(fg_rgb));

  a_r7_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_valid) && !$past(is_cmd) && shown && $past(shown)) |-> fg_rgb == $past(fg_rgb));

  a_r3_red_select: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_valid) && ($past(lc) == 8'h77) && shown) |-> fg_rgb == 9'h1C0);
endmodule

bind kbd_cmd_decoder kbd_cmd_decoder_chk u_chk (.*);

// File: tb/test_kbd_cmd_decoder.sv
module test_kbd_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic       draw_px = 1'b1;
  logic       video_active = 1'b1;
  logic [8:0] fg_rgb;
  logic       start_pulse;

  int compared = 0;
  int mismatched = 0;
  logic [8:0] exp_col;

  always #5 clk = ~clk;

  kbd_cmd_decoder i_kbd_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .draw_px(draw_px), .video_active(video_active),
    .fg_rgb(fg_rgb), .start_pulse(start_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model_col(input logic [7:0] b, input logic [8:0] cur);
    case (b | 8'h20)
      8'h71: return 9'h1FF;
      8'h77: return 9'h1C0;
      8'h65: return 9'h038;
      8'h72: return 9'h007;
      default: return cur;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] b);
    case (b | 8'h20)
      8'h71: return "R2";
      8'h77: return "R3";
      8'h65: return "R4";
      8'h72: return "R5";
      8'h74: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send(input logic [7:0] b, input logic v);
    @(negedge clk);
    rx_byte = b; rx_valid = v;
    @(negedge clk);
    rx_valid = 1'b0;
    if (v) exp_col = model_col(b, exp_col);
    check(v ? tag_of(b) : "R8", {23'd0, fg_rgb}, {23'd0, exp_col});
    check(v ? "R6" : "R8", {31'd0, start_pulse}, {31'd0, v && ((b | 8'h20) == 8'h74)});
    @(negedge clk);
    check("R6", {31'd0, start_pulse}, 32'd0);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    exp_col = 9'h1FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {23'd0, fg_rgb}, 32'h1FF);
    check("R1", {31'd0, start_pulse}, 32'd0);

    // R10: colour visible one cycle after strobe
    @(negedge clk);
    rx_byte = 8'h45; rx_valid = 1'b1;
    #1 check("R10", {23'd0, fg_rgb}, 32'h1FF);
    @(negedge clk);
    rx_valid = 1'b0; exp_col = 9'h038;
    check("R10", {23'd0, fg_rgb}, 32'h038);

    // R2..R7: every byte value strobed, from a non-white start
    send(8'h57, 1'b1);
    for (int i = 0; i < 256; i++) begin
      send(i[7:0], 1'b1);
      if (exp_col == 9'h1FF) send(8'h52, 1'b1);
    end

    // R8: every byte without strobe
    send(8'h77, 1'b1);
    for (int i = 0; i < 256; i++) send(i[7:0], 1'b0);

    // R9: gating under each palette entry
    for (int k = 0; k < 4; k++) begin
      logic [7:0] key;
      key = (k == 0) ? 8'h51 : (k == 1) ? 8'h57 : (k == 2) ? 8'h45 : 8'h52;
      send(key, 1'b1);
      for (int f = 0; f < 4; f++) begin
        @(negedge clk);
        draw_px = f[0]; video_active = f[1];
        #1 check("R9", {23'd0, fg_rgb}, (f == 3) ? {23'd0, exp_col} : 32'd0);
      end
      draw_px = 1'b1; video_active = 1'b1;
    end

    // R1: reset returns to white
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; exp_col = 9'h1FF;
    check("R1", {23'd0, fg_rgb}, 32'h1FF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule